// File: doc/BRIEF.md
# Oscillator-Count Thermal Level Monitor

The block measures die temperature indirectly. A ring oscillator whose rate depends on temperature delivers one pulse per edge on a per-channel input. A shared reference tick times a repeating measurement period. For the first part of each period a counter gathers oscillator pulses. At the end of that span the count is latched and marked valid. The count then sets a thermal level from 0 to 3. The oscillator slows as the die heats, so a lower count means a hotter die.

Each level drives an action, and each action has its own enable. Level 1 requests a voltage/frequency step. Level 2 requests divide-by-two clock throttling. Level 3 requests an emergency reset. Upward threshold crossings and counter saturation set sticky pending flags, which raise the interrupt. Software clears them by writing back the status word it read. Two identical channels sit behind one flat register port. A write takes one cycle and a read is combinational, so the port never stalls and carries no back-pressure. The reference tick and the oscillator pulses are one-cycle strobes in the block clock domain.

Top module: `thermlvl_mon`

## Requirements
- R1: After reset every register reads 0, the valid flag is clear, and `dvfs_req`, `throttle`, `therm_rst` and `irq` are low.
- R2: A channel is idle while control bit 0 (stop) is 1, or the period field M (control bits 23:8) is 0, or the span field N (control bits 31:24) is 0. An idle channel holds its phase and pulse counter at 0, clears the valid flag (status bit 9) and forces its level to 0. The count register keeps its last value.
- R3: While a channel is running, each reference tick advances a phase counter, which wraps to 0 after M ticks. Oscillator pulses are counted while the phase is below min(N, M). On the tick that ends this span, the count, including any pulse in that same cycle, is latched into bits 31:16 of the count register (offset 0x1C) and the valid flag is set.
- R4: The pulse counter saturates at all ones. A latched all-ones count sets the state field (status bits 2:0) to 5 and the level to 0, and all three action outputs of that channel go low.
- R5: The level is the highest k whose threshold satisfies count <= THk. TH1 sits at offset 0x08 bits 15:0, TH2 at offset 0x08 bits 31:16, and TH3 at offset 0x0C bits 15:0. The upper half of 0x0C reads 0. Outside saturation, status bits 2:0 show the level.
- R6: `dvfs_req` is control bit 3 AND level >= 1. `throttle` is control bit 1 AND level >= 2. `therm_rst` is control bit 2 AND level = 3. All three follow the held level, not a pulse.
- R7: At a latch, each threshold crossed upward sets its sticky pending bit if that crossing is enabled. Status bit 7 is set for level 1 (enabled by control bit 3). Status bit 5 is set for level 2 (enabled by control bit 5). Status bit 6 is set for level 3 (enabled by control bit 6). A saturated latch sets status bit 4 when control bit 4 is 1. Status bit 8 is the OR of bits 7:4, and `irq` is the OR of bit 8 over all channels.
- R8: A latch whose level is equal to or lower than the held level sets no level pending bit.
- R9: A write to the status word (offset 0x18) clears each pending bit whose written bit is 1 and changes nothing else. A bit set by a latch in the same cycle stays set.
- R10: Channel k decodes at base 0x40*(k+1), with the offsets above added to the base. Any other address reads 0, and writes to it are ignored.
- R11: The control word and the TH1/TH2 word read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ref_tick | input | 1 | Reference clock strobe, one cycle wide |
| osc_pulse | input | NCH | Oscillator pulse per channel, one cycle wide |
| dvfs_req | output | NCH | Level-1 voltage/frequency request per channel |
| throttle | output | NCH | Level-2 divide-by-two throttle per channel |
| therm_rst | output | NCH | Level-3 emergency reset request per channel |
| irq | output | 1 | Any channel has a pending flag |

## Verification
The bench drives random pulse densities, so measured counts sweep every level in both directions, and it also changes the enable bits at random. It targets four corners. A span equal to the period must latch and wrap on the same tick; getting this wrong would double count or lose the final pulse. A cooling sequence must leave the pending bits clear; a design that flagged any level change would interrupt there. A write-back clear must remove only the written bits. A saturating window must report state 5 with the outputs low; a design that wrapped the counter would show a tiny count and claim level 3.

// File: rtl/thermlvl_pkg.sv
package thermlvl_pkg;
  localparam int REG_W = 32;
  localparam int OFF_W = 5;

  localparam logic [OFF_W-1:0] OFF_CTRL = 5'h00;
  localparam logic [OFF_W-1:0] OFF_THLO = 5'h08;
  localparam logic [OFF_W-1:0] OFF_THHI = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_STAT = 5'h18;
  localparam logic [OFF_W-1:0] OFF_CNT  = 5'h1C;

  localparam logic [2:0] STATE_SAT = 3'd5;

  // pending flag slots, status bits 7:4 map onto pend[3:0]
  localparam int PND_SAT = 0;
  localparam int PND_L2  = 1;
  localparam int PND_L3  = 2;
  localparam int PND_L1  = 3;

  typedef logic [1:0] level_t;

  typedef struct packed {
    logic [7:0]  span;    // 31:24 counted ticks
    logic [15:0] period;  // 23:8  ticks per measurement
    logic        rsv;     // 7
    logic        ie_l3;   // 6
    logic        ie_l2;   // 5
    logic        ie_sat;  // 4
    logic        l1_en;   // 3
    logic        l3_en;   // 2
    logic        l2_en;   // 1
    logic        stop;    // 0
  } ctrl_t;
endpackage

// File: rtl/thermlvl_window.sv
module thermlvl_window #(
  parameter int CNT_W = 16,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PH_W-1:0]  period,
  input  logic [PH_W-1:0]  span,
  input  logic             ref_tick,
  input  logic             osc_pulse,
  output logic             done,
  output logic [CNT_W-1:0] sample
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  span_eff;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_inc;
  logic             gate;
  logic             wrap;

  assign span_eff = (span < period) ? span : period;
  assign gate     = phase_q < span_eff;
  assign acc_inc  = (osc_pulse && gate && acc_q != CNT_MAX) ? acc_q + 1'b1 : acc_q;
  assign done     = run && ref_tick && (phase_q == span_eff - 1'b1);
  assign wrap     = run && ref_tick && (phase_q >= period - 1'b1);
  assign sample   = acc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (!run) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else begin
      if (ref_tick) phase_q <= wrap ? '0 : phase_q + 1'b1;
      acc_q <= wrap ? '0 : acc_inc;
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_q == '0 && phase_q == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap && acc_q == CNT_MAX) |=> acc_q == CNT_MAX); // R4
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !gate && !wrap) |=> $stable(acc_q)); // R3
endmodule

// File: rtl/thermlvl_classify.sv
module thermlvl_classify
  import thermlvl_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NLVL  = 3
) (
  input  logic [CNT_W-1:0]           cnt,
  input  logic [NLVL-1:0][CNT_W-1:0] th,
  output level_t                     lvl,
  output logic                       sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_comb begin
    sat = (cnt == CNT_MAX);
    lvl = '0;
    if (!sat) begin
      for (int k = 0; k < NLVL; k++) begin
        if (cnt <= th[k]) lvl = level_t'(k + 1);
      end
    end
  end
endmodule

// File: rtl/thermlvl_chan.sv
module thermlvl_chan
  import thermlvl_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PH_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [REG_W-1:0]  wdata,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [REG_W-1:0]  rdata,
  input  logic              ref_tick,
  input  logic              osc_pulse,
  output logic              dvfs_req,
  output logic              throttle,
  output logic              therm_rst,
  output logic              intr
);
  ctrl_t            ctrl_q;
  logic [31:0]      thlo_q;
  logic [15:0]      thhi_q;
  logic             valid_q;
  logic             sat_q;
  level_t           lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       pend_q;
  logic [3:0]       pend_set;
  logic [3:0]       pend_clr;
  logic             run;
  logic             done;
  logic [CNT_W-1:0] sample;
  level_t           lvl_new;
  logic             sat_new;
  logic [2:0][CNT_W-1:0] th;
  logic [2:0]       state;
  logic [15:0]      cnt16;

  assign run = !ctrl_q.stop && (ctrl_q.period != '0) && (ctrl_q.span != '0);

  thermlvl_window #(.CNT_W(CNT_W), .PH_W(PH_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .period    (PH_W'(ctrl_q.period)),
    .span      (PH_W'(ctrl_q.span)),
    .ref_tick  (ref_tick),
    .osc_pulse (osc_pulse),
    .done      (done),
    .sample    (sample)
  );

  assign th[0] = CNT_W'(thlo_q[15:0]);
  assign th[1] = CNT_W'(thlo_q[31:16]);
  assign th[2] = CNT_W'(thhi_q);

  thermlvl_classify #(.CNT_W(CNT_W), .NLVL(3)) u_cls (
    .cnt (sample),
    .th  (th),
    .lvl (lvl_new),
    .sat (sat_new)
  );

  always_comb begin
    pend_set = '0;
    if (done) begin
      if (sat_new) begin
        pend_set[PND_SAT] = ctrl_q.ie_sat;
      end else begin
        pend_set[PND_L1] = ctrl_q.l1_en && (lvl_new >= 2'd1) && (lvl_q < 2'd1);
        pend_set[PND_L2] = ctrl_q.ie_l2 && (lvl_new >= 2'd2) && (lvl_q < 2'd2);
        pend_set[PND_L3] = ctrl_q.ie_l3 && (lvl_new == 2'd3) && (lvl_q != 2'd3);
      end
    end
    pend_clr = (wr_en && wr_off == OFF_STAT) ? wdata[7:4] : 4'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      thlo_q  <= '0;
      thhi_q  <= '0;
      valid_q <= 1'b0;
      sat_q   <= 1'b0;
      lvl_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_en && wr_off == OFF_CTRL) ctrl_q <= ctrl_t'(wdata);
      if (wr_en && wr_off == OFF_THLO) thlo_q <= wdata;
      if (wr_en && wr_off == OFF_THHI) thhi_q <= wdata[15:0];
      if (!run) begin
        valid_q <= 1'b0;
        sat_q   <= 1'b0;
        lvl_q   <= '0;
      end else if (done) begin
        valid_q <= 1'b1;
        sat_q   <= sat_new;
        lvl_q   <= lvl_new;
        cnt_q   <= sample;
      end
      pend_q <= (pend_q & ~pend_clr) | pend_set;
    end
  end

  assign state     = sat_q ? STATE_SAT : {1'b0, lvl_q};
  assign intr      = |pend_q;
  assign dvfs_req  = ctrl_q.l1_en && (lvl_q >= 2'd1);
  assign throttle  = ctrl_q.l2_en && (lvl_q >= 2'd2);
  assign therm_rst = ctrl_q.l3_en && (lvl_q == 2'd3);
  assign cnt16     = 16'(cnt_q);

  always_comb begin
    unique case (rd_off)
      OFF_CTRL: rdata = ctrl_q;
      OFF_THLO: rdata = thlo_q;
      OFF_THHI: rdata = {16'b0, thhi_q};
      OFF_STAT: rdata = {22'b0, valid_q, intr, pend_q, 1'b0, state};
      OFF_CNT:  rdata = {cnt16, 16'b0};
      default:  rdata = '0;
    endcase
  end

  AST_STOP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.stop |=> !valid_q); // R2
  AST_SAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> !(dvfs_req || throttle || therm_rst)); // R4
  AST_L3_RISE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[PND_L3]) |-> (lvl_q == 2'd3 && $past(lvl_q) != 2'd3)); // R7
  AST_NO_DOWN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q <= $past(lvl_q)) |-> !($rose(pend_q[PND_L1]) || $rose(pend_q[PND_L2]) || $rose(pend_q[PND_L3]))); // R8
  AST_RST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    therm_rst |-> valid_q); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr[PND_SAT] && !pend_set[PND_SAT]) |=> !pend_q[PND_SAT]); // R9
endmodule

// File: rtl/thermlvl_mon.sv
module thermlvl_mon
  import thermlvl_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ref_tick,
  input  logic [NCH-1:0]   osc_pulse,
  output logic [NCH-1:0]   dvfs_req,
  output logic [NCH-1:0]   throttle,
  output logic [NCH-1:0]   therm_rst,
  output logic             irq
);
  localparam int SEL_W = AW - 6;

  logic [NCH-1:0]            sel;
  logic [NCH-1:0]            intr;
  logic [NCH-1:0][REG_W-1:0] ch_rdata;
  logic [OFF_W-1:0]          off;

  assign off = bus_addr[OFF_W-1:0];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign sel[k] = (bus_addr[AW-1:6] == SEL_W'(k + 1)) && !bus_addr[5];

    thermlvl_chan #(.CNT_W(CNT_W), .PH_W(16)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr && sel[k]),
      .wr_off    (off),
      .wdata     (bus_wdata),
      .rd_off    (off),
      .rdata     (ch_rdata[k]),
      .ref_tick  (ref_tick),
      .osc_pulse (osc_pulse[k]),
      .dvfs_req  (dvfs_req[k]),
      .throttle  (throttle[k]),
      .therm_rst (therm_rst[k]),
      .intr      (intr[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (sel[k]) bus_rdata = bus_rdata | ch_rdata[k];
    end
  end

  assign irq = |intr;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (bus_rdata == '0)); // R10
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R10
endmodule

// File: tb/thermlvl_mon_tb.sv
module thermlvl_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic [1:0]  osc_pulse = '0;
  logic [1:0]  dvfs_req, throttle, therm_rst;
  logic        irq;

  thermlvl_mon u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
    .osc_pulse(osc_pulse), .dvfs_req(dvfs_req), .throttle(throttle),
    .therm_rst(therm_rst), .irq(irq)
  );

  always #2 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit done_f = 0, chk_en = 0;
  int tick_per = 2, tc = 0;
  int dens [2] = '{8, 8};

  // stimulus generator
  always @(negedge clk) begin
    if (tc >= tick_per - 1) begin tc = 0; ref_tick = 1'b1; end
    else begin tc++; ref_tick = 1'b0; end
    for (int c = 0; c < 2; c++) osc_pulse[c] = (($urandom % 16) < dens[c]);
  end

  // requirement model
  logic [31:0] m_cfg [2], m_tlo [2], m_thi [2];
  int mp [2], mo [2], mcnt [2], mlvl [2];
  bit mval [2], movf [2];
  logic [3:0] mpend [2];

  function automatic int level_of(int cnt, logic [31:0] tlo, logic [31:0] thi);
    if (cnt <= thi[15:0]) return 3;
    if (cnt <= tlo[31:16]) return 2;
    if (cnt <= tlo[15:0]) return 1;
    return 0;
  endfunction

  task automatic model_step(int c);
    logic [31:0] cf = m_cfg[c];
    int mv = cf[23:8], nv = cf[31:24];
    bit run = !cf[0] && mv != 0 && nv != 0;
    int neff = (nv < mv) ? nv : mv;
    logic [3:0] set = '0, clr = '0;
    logic [7:0] base = 8'(8'h40 * (c + 1));
    int oi, nl;
    bit lat, wr;
    if (bus_wr && bus_addr == base + 8'h18) clr = bus_wdata[7:4];
    if (!run) begin
      mp[c] = 0; mo[c] = 0; mval[c] = 0; mlvl[c] = 0; movf[c] = 0;
    end else begin
      oi  = mo[c] + ((osc_pulse[c] && mp[c] < neff && mo[c] != 65535) ? 1 : 0);
      lat = ref_tick && (mp[c] == neff - 1);
      wr  = ref_tick && (mp[c] >= mv - 1);
      if (ref_tick) mp[c] = wr ? 0 : mp[c] + 1;
      mo[c] = wr ? 0 : oi;
      if (lat) begin
        mcnt[c] = oi; mval[c] = 1;
        if (oi == 65535) begin
          movf[c] = 1; mlvl[c] = 0; set[0] = cf[4];
        end else begin
          nl = level_of(oi, m_tlo[c], m_thi[c]);
          if (nl >= 1 && mlvl[c] < 1) set[3] = cf[3];
          if (nl >= 2 && mlvl[c] < 2) set[1] = cf[5];
          if (nl == 3 && mlvl[c] < 3) set[2] = cf[6];
          movf[c] = 0; mlvl[c] = nl;
        end
      end
    end
    mpend[c] = (mpend[c] & ~clr) | set;
    if (bus_wr && bus_addr == base)         m_cfg[c] = bus_wdata;
    if (bus_wr && bus_addr == base + 8'h08) m_tlo[c] = bus_wdata;
    if (bus_wr && bus_addr == base + 8'h0C) m_thi[c] = {16'b0, bus_wdata[15:0]};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cfg[c] = 0; m_tlo[c] = 0; m_thi[c] = 0; mp[c] = 0; mo[c] = 0;
        mcnt[c] = 0; mlvl[c] = 0; mval[c] = 0; movf[c] = 0; mpend[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) model_step(c);
    end
  end

  function automatic logic [31:0] exp_stat(int c);
    logic [2:0] st = movf[c] ? 3'd5 : 3'(mlvl[c]);
    return {22'b0, mval[c], |mpend[c], mpend[c], 1'b0, st};
  endfunction

  function automatic logic [31:0] exp_outs();
    logic [1:0] d, t, r;
    for (int c = 0; c < 2; c++) begin
      d[c] = m_cfg[c][3] && mlvl[c] >= 1;
      t[c] = m_cfg[c][1] && mlvl[c] >= 2;
      r[c] = m_cfg[c][2] && mlvl[c] == 3;
    end
    return {25'b0, d, t, r, (|mpend[0]) || (|mpend[1])};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_chan(int c, string tag);
    logic [31:0] d;
    logic [7:0] base = 8'(8'h40 * (c + 1));
    rd(base + 8'h18, d); chk({tag, " status"}, d, exp_stat(c));
    rd(base + 8'h1C, d); chk({tag, " count"}, d, {16'(mcnt[c]), 16'b0});
  endtask

  // per-cycle action outputs and interrupt
  always @(negedge clk) begin
    if (chk_en) begin
      #1 chk("R6 R7 outputs", {25'b0, dvfs_req, throttle, therm_rst, irq}, exp_outs());
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done_f) begin
      nbad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h40, d); chk("R1 ctrl", d, 0);
    rd(8'h58, d); chk("R1 status", d, 0);
    rd(8'h9C, d); chk("R1 count", d, 0);
    #1 chk("R1 outputs", {28'b0, dvfs_req, throttle, therm_rst, irq} & 32'h7F, 0);

    // thresholds: ch0 14/9/4, ch1 12/8/3
    wr(8'h48, {16'd9, 16'd14}); wr(8'h4C, 32'hABCD_0004);
    wr(8'h88, {16'd8, 16'd12}); wr(8'h8C, 32'd3);
    rd(8'h48, d); chk("R11 thresholds", d, {16'd9, 16'd14});
    rd(8'h4C, d); chk("R5 TH3 upper half", d, 32'd4);

    // R2 zero period keeps channel idle
    wr(8'h40, {8'd10, 16'd0, 8'h7E});
    repeat (100) @(negedge clk);
    rd(8'h58, d); chk("R2 zero period valid", d[9], 0);

    chk_en = 1;
    wr(8'h40, {8'd10, 16'd20, 8'h7E});
    rd(8'h40, d); chk("R11 ctrl readback", d, {8'd10, 16'd20, 8'h7E});
    wr(8'h80, {8'd15, 16'd15, 8'h7E});  // span equals period
    repeat (60) @(negedge clk);
    chk_chan(0, "R3 first window");
    chk_chan(1, "R10 R3 second channel");

    // random sweep
    for (int i = 0; i < 60; i++) begin
      dens[0] = $urandom % 17; dens[1] = $urandom % 17;
      repeat (50 + $urandom % 40) @(negedge clk);
      chk_chan(0, "R5 R7 ch0");
      chk_chan(1, "R5 R7 ch1");
      if ($urandom % 3 == 0) begin
        rd(8'h58, d); wr(8'h58, d);
        chk_chan(0, "R9 writeback");
      end
      if ($urandom % 4 == 0) wr(8'h40, {8'd10, 16'd20, 1'b0, 6'($urandom), 1'b0});
    end

    // R8 heating then cooling
    wr(8'h40, {8'd10, 16'd20, 8'h7E});
    dens[0] = 0;
    repeat (150) @(negedge clk);
    chk_chan(0, "R5 hot level 3");
    rd(8'h58, d); chk("R5 state 3", d[2:0], 3);
    wr(8'h58, 32'h0000_00F0);
    rd(8'h58, d); chk("R9 cleared", d[8:4], 0);
    dens[0] = 16;
    repeat (150) @(negedge clk);
    rd(8'h58, d); chk("R8 no pend on cooling", d[8:4], 0);
    chk_chan(0, "R8 cool");

    // R2 stop
    wr(8'h40, {8'd10, 16'd20, 8'h7F});
    repeat (5) @(negedge clk);
    rd(8'h58, d); chk("R2 stop clears valid", d[9], 0);
    chk_chan(0, "R2 stopped");

    // R10 unmapped addresses
    rd(8'h04, d); chk("R10 low hole", d, 0);
    rd(8'h60, d); chk("R10 upper half of slot", d, 0);
    rd(8'hD8, d); chk("R10 missing channel", d, 0);

    // R4 saturation
    tick_per = 260;
    wr(8'h40, {8'd255, 16'd255, 8'h7E});
    repeat (67000) @(negedge clk);
    rd(8'h5C, d); chk("R4 saturated count", d, 32'hFFFF_0000);
    rd(8'h58, d); chk("R4 state 5", d[2:0], 5);
    chk("R4 sat pending", d[4], 1);
    chk_chan(0, "R4 model");
    chk_chan(1, "R4 ch1 model");

    chk_en = 0;
    done_f = 1;
    summary();
    $finish;
  end
endmodule